// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (64 x 16)

This block models a 64-word by 16-bit serial EEPROM as seen from its three-wire control interface: a select line, a serial clock, a serial data input and a serial data output with its own output enable. The block runs on a fast system clock. It samples the serial clock and the select line on that clock and acts on each rising edge of the serial clock. A frame opens with a start bit. A two-bit command code follows, then a six-bit word address sent high bit first, and then sixteen data bits sent high bit first for the commands that carry data. The storage is a register array. Every word holds all ones after reset.

Reads send a zero placeholder bit and then the addressed word. The address then advances for as long as clocks continue. Any change to the array needs a prior enable command. The change is committed when the select line drops after a complete frame. A parameterized write period follows, and during it the block ignores new commands. While the select line is high in that period, the data output reports busy or ready.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset every word reads 16'hFFFF, writes are disabled, and dout_oe is 0.
- R2: While cs is high, 0 bits on di before the first 1 are ignored, and the first 1 sampled on a serial clock rise is taken as the start bit.
- R3: Command code 2'b10 reads. On the serial clock rise that captures the last address bit, dout_oe goes to 1 and dout shows 0. Each later rise then presents the next bit of the addressed word, bit 15 first.
- R4: If clocking continues after a read word, the words at the following addresses are sent back to back, and address 63 is followed by address 0.
- R5: Writes are disabled after reset. While disabled, the WRITE, ERASE, write-all and erase-all commands change nothing and start no write period. Reads work in either state.
- R6: Code 2'b00 with address bits [5:4] = 2'b11 enables writes, and with [5:4] = 2'b00 disables them. Address bits [3:0] are ignored.
- R7: Code 2'b01 (WRITE) stores the 16 data bits at the address. The store happens only if cs falls after the 25th serial clock counted from the start bit. A frame cut short stores nothing.
- R8: Code 2'b11 (ERASE) sets the addressed word to 16'hFFFF. Code 2'b00 with [5:4] = 2'b10 sets all 64 words to 16'hFFFF.
- R9: Code 2'b00 with [5:4] = 2'b01, followed by 16 data bits, stores that value in all 64 words in one write period.
- R10: A write period lasts WRITE_CYCLES system clocks from the fall of cs. While it lasts, cs high gives dout_oe = 1 and dout = 0. After it ends, cs high gives dout = 1 until the next start bit.
- R11: During a write period, no bit on di is taken as a start bit or a command.
- R12: While cs is low, dout_oe is 0. Dropping cs cancels any read or partial frame, and the next frame is decoded from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; bits are captured and launched on its rise |
| di | input | 1 | Serial data input |
| dout | output | 1 | Serial data output: read data or ready/busy status |
| dout_oe | output | 1 | Output enable for dout; 0 means high impedance |

## Verification
Reads are exercised on erased words, on freshly written words, across a word boundary and across the wrap from 63 to 0. Comparing the streamed bits with a bench-side copy of the array separates addressing faults from shift-order faults. Each array-changing command is issued with writes enabled, with writes disabled and with the frame cut short. This tells a missing enable gate apart from a missing 25-clock rule. The busy check sends a complete read command during the write period and expects to see only the busy level. A read cancelled midway and followed by a fresh read shows that dropping the select line fully resets the decoder.

// File: rtl/mw_pkg.sv
// Shared types and command codes for the three-wire EEPROM slave.
// Assumes a frame of start bit, 2-bit code, address, optional data.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,   // hunting for the start bit
        ST_OP,     // shifting the command code
        ST_ADDR,   // shifting the word address
        ST_DATA,   // shifting write data
        ST_READ,   // streaming read data
        ST_ARMED,  // write complete, waiting for cs to fall
        ST_HOLD    // frame finished, nothing pending
    } mw_state_t;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_LOCK  = 2'b00;
    localparam logic [1:0] EXT_FILL  = 2'b01;
    localparam logic [1:0] EXT_CLEAR = 2'b10;
    localparam logic [1:0] EXT_OPEN  = 2'b11;

endpackage

// File: rtl/mw_edge_sync.sv
// Edge detector for the serial clock and the chip select.
// Assumes sk and cs are synchronous to clk and slower than it.
module mw_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    input  logic cs,
    output logic sk_rise,
    output logic cs_fall
);
    logic sk_q;
    logic cs_q;

    // Remember last-cycle levels of sk and cs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    // Single-cycle pulses on edges.
    always_comb begin
        sk_rise = sk & ~sk_q;
        cs_fall = cs_q & ~cs;
    end
endmodule

// File: rtl/mw_write_timer.sv
// Counts out the write period after a commit pulse.
// Assumes start never arrives while busy is high.
module mw_write_timer #(
    parameter int WRITE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(WRITE_CYCLES + 1);
    logic [TW-1:0] left_q;

    // Load on commit, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (start)          left_q <= TW'(WRITE_CYCLES);
        else if (left_q != '0)   left_q <= left_q - TW'(1);
    end

    // Busy while count remains.
    always_comb busy = (left_q != '0);

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R10
endmodule

// File: rtl/mw_cmd_fsm.sv
// Frame decoder: start-bit hunt, code and address shift, write data
// capture, read streaming with auto-increment. Assumes one step per
// sk_rise and the array read combinationally through rd_addr/rd_word.
module mw_cmd_fsm
    import mw_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          di,
    input  logic          sk_rise,
    input  logic          busy,
    input  logic          wen,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] rd_addr,
    output logic          rd_active,
    output logic          rd_bit,
    output logic          armed,
    output logic          arm_all,
    output logic [AW-1:0] arm_addr,
    output logic [DW-1:0] arm_word,
    output logic          wen_set,
    output logic          wen_clr,
    output logic          frame_go
);
    localparam int CW = $clog2((DW > AW) ? DW : AW);

    mw_state_t      state_q;
    logic [1:0]     op_q;
    logic [AW-1:0]  addr_q;
    logic [AW-1:0]  a_next;
    logic [CW-1:0]  cnt_q;
    logic [DW-1:0]  sh_q;

    // Address with the current di bit shifted in.
    always_comb a_next = {addr_q[AW-2:0], di};

    // Array read port: the next word while streaming, else the new address.
    always_comb rd_addr = (state_q == ST_READ) ? addr_q + AW'(1) : a_next;

    // Decoded views of the state.
    always_comb begin
        rd_active = (state_q == ST_READ);
        armed     = (state_q == ST_ARMED);
        arm_addr  = addr_q;
        arm_word  = sh_q;
        frame_go  = cs & sk_rise & di & ~busy & (state_q == ST_WAIT);
    end

    // Frame sequencing on each serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            op_q    <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            sh_q    <= '0;
            rd_bit  <= 1'b0;
            arm_all <= 1'b0;
            wen_set <= 1'b0;
            wen_clr <= 1'b0;
        end else begin
            wen_set <= 1'b0;
            wen_clr <= 1'b0;
            if (!cs) begin
                state_q <= ST_WAIT;
            end else if (sk_rise) begin
                case (state_q)
                    ST_WAIT: if (frame_go) begin
                        state_q <= ST_OP;
                        cnt_q   <= '0;
                        arm_all <= 1'b0;
                    end
                    ST_OP: begin
                        op_q  <= {op_q[0], di};
                        cnt_q <= cnt_q + CW'(1);
                        if (cnt_q == CW'(1)) begin
                            state_q <= ST_ADDR;
                            cnt_q   <= '0;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= a_next;
                        cnt_q  <= cnt_q + CW'(1);
                        if (cnt_q == CW'(AW-1)) begin
                            cnt_q <= '0;
                            case (op_q)
                                OP_READ: begin
                                    state_q <= ST_READ;
                                    rd_bit  <= 1'b0;
                                    sh_q    <= rd_word;
                                end
                                OP_WRITE: state_q <= ST_DATA;
                                OP_ERASE: begin
                                    sh_q    <= '1;
                                    state_q <= wen ? ST_ARMED : ST_HOLD;
                                end
                                default: begin
                                    case (a_next[AW-1 -: 2])
                                        EXT_OPEN: begin
                                            wen_set <= 1'b1;
                                            state_q <= ST_HOLD;
                                        end
                                        EXT_LOCK: begin
                                            wen_clr <= 1'b1;
                                            state_q <= ST_HOLD;
                                        end
                                        EXT_FILL: begin
                                            arm_all <= 1'b1;
                                            state_q <= ST_DATA;
                                        end
                                        default: begin
                                            arm_all <= 1'b1;
                                            sh_q    <= '1;
                                            state_q <= wen ? ST_ARMED : ST_HOLD;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        sh_q  <= {sh_q[DW-2:0], di};
                        cnt_q <= cnt_q + CW'(1);
                        if (cnt_q == CW'(DW-1))
                            state_q <= wen ? ST_ARMED : ST_HOLD;
                    end
                    ST_READ: begin
                        rd_bit <= sh_q[DW-1];
                        sh_q   <= {sh_q[DW-2:0], 1'b0};
                        cnt_q  <= cnt_q + CW'(1);
                        if (cnt_q == CW'(DW-1)) begin
                            sh_q   <= rd_word;
                            addr_q <= addr_q + AW'(1);
                            cnt_q  <= '0;
                        end
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state_q == ST_WAIT)); // R11
    AST_DESELECT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state_q == ST_WAIT)); // R12
    AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |-> !rd_bit); // R3
endmodule

// File: rtl/mw_eeprom_slave.sv
// Top: 64x16 register array, write-enable latch, ready/busy status and
// output mux around the frame decoder and write timer. Assumes sk/cs/di
// are synchronous to clk; commits happen at the fall of cs.
module mw_eeprom_slave #(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 16,
    parameter int WRITE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              sk_rise, cs_fall, busy, wen_q, status_q;
    logic [ADDR_W-1:0] rd_addr, arm_addr;
    logic [DATA_W-1:0] rd_word, arm_word;
    logic              rd_active, rd_bit, armed, arm_all;
    logic              wen_set, wen_clr, frame_go, wr_start;

    mw_edge_sync u_edge (
        .clk(clk), .rst_n(rst_n), .sk(sk), .cs(cs),
        .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    mw_cmd_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .sk_rise(sk_rise),
        .busy(busy), .wen(wen_q), .rd_word(rd_word), .rd_addr(rd_addr),
        .rd_active(rd_active), .rd_bit(rd_bit), .armed(armed),
        .arm_all(arm_all), .arm_addr(arm_addr), .arm_word(arm_word),
        .wen_set(wen_set), .wen_clr(wen_clr), .frame_go(frame_go)
    );

    mw_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy)
    );

    // Commit a completed, enabled frame when select drops.
    always_comb wr_start = cs_fall & armed;

    // Array read port.
    always_comb rd_word = mem_q[rd_addr];

    // Array update: erased at reset, one word or all words on commit.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem_q[i] <= '1;
            else if (wr_start && (arm_all || ADDR_W'(i) == arm_addr))
                mem_q[i] <= arm_word;
        end
    end

    // Write-enable latch, closed at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       wen_q <= 1'b0;
        else if (wen_set) wen_q <= 1'b1;
        else if (wen_clr) wen_q <= 1'b0;
    end

    // Status reporting armed by a commit, dropped by the next start bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        status_q <= 1'b0;
        else if (wr_start) status_q <= 1'b1;
        else if (frame_go) status_q <= 1'b0;
    end

    // Output mux and enable.
    always_comb begin
        dout_oe = cs & (rd_active | status_q);
        dout    = status_q ? ~busy : rd_bit;
    end

    AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> wen_q); // R5
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> !busy); // R11
endmodule

// File: tb/mw_eeprom_slave_tb.sv
// Scoreboard bench: read tasks queue expected bits, a monitor pops them
// on each serial clock fall and compares with dout.
module mw_eeprom_slave_tb_top;
    localparam int WR = 300;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    wire  dout, dout_oe;

    int total = 0, bad = 0;
    logic [15:0] model [64];
    logic  exp_q [$];
    bit    mon_en = 1'b0;
    string cur_req = "R3";

    always #5 clk = ~clk;

    mw_eeprom_slave #(.WRITE_CYCLES(WR)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        di = b; tick(2); sk = 1'b1; tick(3); sk = 1'b0; tick(2);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
    endtask

    // Monitor: pop and compare one expected bit per serial clock.
    always @(negedge sk) begin : mon
        logic e;
        if (mon_en) begin
            if (exp_q.size() == 0) check(1'b0, cur_req, 0, 1);
            else begin
                e = exp_q.pop_front();
                check(dout_oe === 1'b1 && dout === e, cur_req,
                      {dout_oe, dout}, {1'b1, e});
            end
        end
    end

    // Driver: read n words from addr with two leading zeros (R2).
    task automatic do_read(input logic [5:0] addr, input int n, input string req);
        cs = 1'b1; tick(2);
        sk_bit(1'b0); sk_bit(1'b0); sk_bit(1'b1);
        send(2'b10, 2); send(32'(addr >> 1), 5);
        exp_q.push_back(1'b0);
        for (int w = 0; w < n; w++)
            for (int b = 15; b >= 0; b--)
                exp_q.push_back(model[6'(addr + w)][b]);
        cur_req = req; mon_en = 1'b1;
        sk_bit(addr[0]);
        for (int k = 0; k < 16 * n; k++) sk_bit(1'b0);
        mon_en = 1'b0;
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
        cs = 1'b0; tick(4);
    endtask

    task automatic frame(input logic [1:0] op, input logic [5:0] a,
                         input logic [15:0] d, input int ndata);
        cs = 1'b1; tick(2);
        sk_bit(1'b1); send(32'(op), 2); send(32'(a), 6);
        for (int i = 15; i > 15 - ndata; i--) sk_bit(d[i]);
        di = 1'b0; cs = 1'b0; tick(3);
    endtask

    task automatic finish_write(input string req);
        cs = 1'b1; tick(3);
        check(dout_oe === 1'b1 && dout === 1'b0, req, {dout_oe, dout}, 2'b10);
        tick(WR + 10);
        check(dout_oe === 1'b1 && dout === 1'b1, req, {dout_oe, dout}, 2'b11);
        cs = 1'b0; tick(3);
    endtask

    task automatic no_status(input string req);
        cs = 1'b1; tick(3);
        check(dout_oe === 1'b0, req, dout_oe, 0);
        cs = 1'b0; tick(3);
    endtask

    task automatic run();
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        tick(4); rst_n = 1'b1; tick(2);
        check(dout_oe === 1'b0, "R1 oe after reset", dout_oe, 0);
        no_status("R1 no status after reset");
        do_read(6'd5, 1, "R1 erased word / R2 leading zeros");

        // R5: write while disabled is ignored.
        frame(2'b01, 6'd3, 16'h1234, 16);
        no_status("R5 no write period when disabled");
        do_read(6'd3, 1, "R5 disabled write ignored");

        // R6 enable, R7 write, R10 status, R11 busy ignores commands.
        frame(2'b00, 6'b110101, 16'h0, 0);
        frame(2'b01, 6'd3, 16'hA5C3, 16); model[3] = 16'hA5C3;
        cs = 1'b1; tick(3);
        send(32'b1_10_000011_0000, 13);
        check(dout_oe === 1'b1 && dout === 1'b0, "R11 busy ignores read",
              {dout_oe, dout}, 2'b10);
        tick(WR);
        check(dout_oe === 1'b1 && dout === 1'b1, "R10 ready", {dout_oe, dout}, 2'b11);
        cs = 1'b0; tick(3);
        do_read(6'd3, 2, "R4 auto-increment / R7 write");

        // R4 wrap from 63 to 0.
        frame(2'b01, 6'd63, 16'h8001, 16); model[63] = 16'h8001;
        finish_write("R10 write 63");
        frame(2'b01, 6'd0, 16'h7E11, 16); model[0] = 16'h7E11;
        finish_write("R10 write 0");
        do_read(6'd63, 2, "R4 wrap 63 to 0");

        // R7 short frame stores nothing.
        frame(2'b01, 6'd10, 16'h5555, 10);
        no_status("R7 short frame no write period");
        do_read(6'd10, 1, "R7 short frame");

        // R8 erase one word.
        frame(2'b11, 6'd3, 16'h0, 0); model[3] = 16'hFFFF;
        finish_write("R8 erase period");
        do_read(6'd3, 1, "R8 erase word");

        // R9 write all.
        frame(2'b00, 6'b010110, 16'h0F0F, 16);
        for (int i = 0; i < 64; i++) model[i] = 16'h0F0F;
        finish_write("R9 write-all period");
        do_read(6'd62, 3, "R9 write all");
        do_read(6'd20, 1, "R9 write all mid");

        // R8 erase all.
        frame(2'b00, 6'b101001, 16'h0, 0);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        finish_write("R8 erase-all period");
        do_read(6'd0, 2, "R8 erase all");

        // R6 disable, then write ignored.
        frame(2'b00, 6'b001111, 16'h0, 0);
        frame(2'b01, 6'd1, 16'h0000, 16);
        no_status("R6 disable blocks write period");
        do_read(6'd1, 1, "R6 disabled write ignored");

        // R12 cancel a read midway.
        cs = 1'b1; tick(2);
        sk_bit(1'b1); send(2'b10, 2); send(32'd7, 6); send(0, 5);
        check(dout_oe === 1'b1, "R12 read active before cancel", dout_oe, 1);
        cs = 1'b0; tick(2);
        check(dout_oe === 1'b0, "R12 hi-z when deselected", dout_oe, 0);
        do_read(6'd7, 1, "R12 fresh read after cancel");
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=0 exp=1");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule